// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Readout Sequencer

This block models the digital side of a multichannel converter that samples all of its channels at the same instant. A rising edge on the conversion-start input latches one input word per channel. A busy flag is then held high for a fixed number of clock cycles. When busy drops, the latched words become the results of the new frame.

A reader fetches the results by pulsing an active-low read strobe. Each falling edge of the strobe puts the next channel onto a 16-bit bus, starting with channel 0. A first-word flag marks the word of channel 0. While the strobe is high, the bus and the flag are released to high impedance. The block is meant as a synthesizable partner for testing a readout controller.

The conversion-start and read-strobe inputs are taken to be synchronous to the clock. Their edges are detected on the system clock.

Top module: `sim_adc_seq`

## Requirements
- R1: The words present on `ch_in` in the clock cycle in which the conversion-start rising edge is detected become the frame results. Later changes of `ch_in` do not affect them. Channel k occupies bits [k*W +: W].
- R2: Busy goes high in the cycle after the conversion-start rising edge is detected. It stays high for exactly CONV_CYCLES cycles.
- R3: A conversion-start rising edge that arrives while busy is high is ignored. It neither extends busy nor recaptures the inputs.
- R4: When busy falls, the results of all channels are available and the read pointer restarts at channel 0.
- R5: Each falling edge of `rd_n` after busy falls presents the next channel on `dbus`, starting with channel 0. The word is valid from the cycle after the edge is detected. All NCH channels are output in ascending order in every frame.
- R6: `first_out` is 1 while channel 0 is presented after the first strobe falling edge of a frame. It is 0 for every later word of the frame.
- R7: One cycle after `rd_n` is sampled high, `dbus` and `first_out` are at high impedance.
- R8: Strobe falling edges after the last channel has been read present the last channel (NCH-1) again.
- R9: After reset, busy is low and `dbus` and `first_out` are at high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Conversion start; a rising edge samples all channels |
| ch_in | input | NCH*W | Per-channel input words, channel k at [k*W +: W] |
| rd_n | input | 1 | Active-low combined select/read strobe |
| busy | output | 1 | High during conversion |
| dbus | output | W | Tri-state result bus |
| first_out | output | 1 | Tri-state flag marking the channel 0 word |

## Verification
The hardest case to reach is a second conversion start that lands inside the busy window with different input words. It must leave both the busy length and the results unchanged. The stimulus raises conversion-start again a few cycles into busy, with a new pattern on the inputs. It keeps counting busy cycles from the first edge and then reads the whole frame, which must still carry the first pattern. The released state of the bus is observed through weak pull-ups in the bench, so a floating bus reads as all ones.

// File: rtl/sim_adc_seq.sv
module sim_adc_seq #(
  parameter int NCH = 8,
  parameter int W = 16,
  parameter int CONV_CYCLES = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv_start,
  input  logic [NCH*W-1:0] ch_in,
  input  logic           rd_n,
  output logic           busy,
  output logic [W-1:0]   dbus,
  output logic           first_out
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [IW-1:0] LAST = IW'(NCH - 1);
  localparam logic [CW-1:0] CLOAD = CW'(CONV_CYCLES - 1);

  logic          conv_q, rd_q, started, first_q;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [W-1:0]  smp [NCH];
  logic [W-1:0]  res [NCH];

  wire conv_rise = conv_start & ~conv_q;
  wire rd_fall   = rd_q & ~rd_n;
  wire done      = busy & (cnt == '0);
  wire take      = conv_rise & ~busy;

  assign dbus      = rd_q ? 'z : res[idx];
  assign first_out = rd_q ? 1'bz : first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_q <= 1'b0;
      rd_q   <= 1'b1;
    end else begin
      conv_q <= conv_start;
      rd_q   <= rd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (take) begin
      busy <= 1'b1;
      cnt  <= CLOAD;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (take) smp[k] <= ch_in[k*W +: W];
      if (done) res[k] <= smp[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      first_q <= 1'b0;
      idx     <= '0;
    end else if (done) begin
      started <= 1'b0;
      first_q <= 1'b0;
      idx     <= '0;
    end else if (rd_fall && !busy) begin
      if (!started) begin
        started <= 1'b1;
        first_q <= 1'b1;
        idx     <= '0;
      end else begin
        first_q <= 1'b0;
        if (idx != LAST) idx <= idx + 1'b1;
      end
    end
  end

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_rise && !busy) |=> busy); // R2
  AST_BUSY_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1)); // R3
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == '0)); // R2
  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (idx == '0 && !started)); // R4
  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !busy && started) |=> !first_q); // R6
  AST_PTR_HOLD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == LAST && !done) |=> idx == LAST); // R8
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST); // R8
endmodule

// File: tb/test_sim_adc_seq.sv
module test_sim_adc_seq;
  localparam int NCH = 8;
  localparam int W = 16;
  localparam int CONV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_start = 1'b0;
  logic [NCH*W-1:0] ch_in = '0;
  logic rd_n = 1'b1;
  logic busy;
  wire [W-1:0] dbus;
  wire first_out;

  int n_tests = 0;
  int n_fail = 0;

  typedef struct {
    logic [W-1:0] data;
    logic         first;
    string        req;
  } exp_t;
  exp_t q[$];
  event mon_ev;

  always #5 clk = ~clk;

  for (genvar i = 0; i < W; i++) begin : g_pu
    pullup (dbus[i]);
  end
  pullup (first_out);

  sim_adc_seq #(.NCH(NCH), .W(W), .CONV_CYCLES(CONV)) i_sim_adc_seq (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .ch_in(ch_in),
    .rd_n(rd_n), .busy(busy), .dbus(dbus), .first_out(first_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always begin
    @(mon_ev);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.req, " data"}, 32'(dbus), 32'(e.data));
      check({e.req, " first"}, 32'(first_out), 32'(e.first));
    end
  end

  function automatic logic [W-1:0] pat(input int seed, input int k);
    return W'(16'h1000 * (seed & 7) + 16'h0111 * k + 16'h0005);
  endfunction

  function automatic logic [NCH*W-1:0] pack(input int seed);
    logic [NCH*W-1:0] v;
    for (int k = 0; k < NCH; k++) v[k*W +: W] = pat(seed, k);
    return v;
  endfunction

  task automatic read_word(input logic [W-1:0] exp, input logic expf, input string req);
    exp_t e;
    @(negedge clk) rd_n = 1'b0;
    @(negedge clk);
    e.data = exp; e.first = expf; e.req = req;
    q.push_back(e);
    ->mon_ev;
    #1;
    @(negedge clk) rd_n = 1'b1;
    @(negedge clk);
    check("R7 bus released", 32'(dbus), 32'(16'hFFFF));
    check("R7 flag released", 32'(first_out), 32'd1);
  endtask

  task automatic read_frame(input int seed);
    for (int k = 0; k < NCH; k++)
      read_word(pat(seed, k), k == 0, (k == 0) ? "R5 R6 R1" : "R5 R6");
  endtask

  task automatic convert(input int seed, input int reseed_at, input int seed2);
    int n;
    n = 0;
    @(negedge clk) begin ch_in = pack(seed); conv_start = 1'b1; end
    @(negedge clk) begin conv_start = 1'b0; ch_in = pack(seed + 3); end
    while (busy && n < 10 * CONV) begin
      n++;
      if (reseed_at > 0 && n == reseed_at) begin ch_in = pack(seed2); conv_start = 1'b1; end
      if (reseed_at > 0 && n == reseed_at + 1) conv_start = 1'b0;
      @(negedge clk);
    end
    check((reseed_at > 0) ? "R3 busy length" : "R2 busy length", 32'(n), 32'(CONV));
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 busy", 32'(busy), 32'd0);
    check("R9 bus", 32'(dbus), 32'(16'hFFFF));
    check("R9 flag", 32'(first_out), 32'd1);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    convert(1, 0, 0);
    check("R4 busy low", 32'(busy), 32'd0);
    read_frame(1);
    read_word(pat(1, NCH - 1), 1'b0, "R8");
    read_word(pat(1, NCH - 1), 1'b0, "R8");

    convert(2, 4, 6);
    read_frame(2);

    convert(5, 0, 0);
    read_word(pat(5, 0), 1'b1, "R4 R5");
    read_word(pat(5, 1), 1'b0, "R5");
    convert(4, 0, 0);
    read_frame(4);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule